// File: doc/BRIEF.md
# System-Control Coprocessor Register Write Unit

This block owns the bank of system-control registers that sit beside a processor pipeline and applies register-move writes to it. A write presents a register select, 32 bits of data and an enable; on the next clock edge the selected register takes the data through its own pair of masks. A preserve mask names bits that hold their old value, a load mask names bits taken from the data, and any bit in neither mask is forced to zero.

Alongside the bank the block keeps four mode flags (user mode, exception level, error level, debug mode) that follow the written Status and debug-control values, a registered hardware interrupt request that is re-evaluated only when a Status write moves the interrupt-enable bit, and a one-cycle translation flush pulse raised when an EntryHi write changes the address-space ID. The full bank is brought out as one flat vector so that the surrounding pipeline can read any register without a separate read path.

Top module: `cp0_write_unit`

## Requirements
- R1: Synchronous reset loads STATUS=0x00400000, CAUSE=0x30000000, TLB_IDX=0x80000000, PT_CTX=0x12800000, CONFIG0=0x80000082, DBG_CTL=0x04000000 and zero into every other register; the error-level flag resets to 1, the other three flags, `irq_req` and `tlb_flush` reset to 0.
- R2: Select codes are STATUS=0, CAUSE=1, EXC_PC=2, ASID_HI=3, PTE_LO0=4, PTE_LO1=5, TLB_IDX=6, PG_MASK=7, WIRED_LIM=8, PT_CTX=9, CONFIG0=10, DBG_CTL=11, DBG_PC=12, DBG_SCRATCH=13, ERR_PC=14, CACHE_TAG=15, WATCH_ADDR=16, WATCH_CTL=17; register k appears on `reg_bank[32k+31:32k]`. A write with `wr_en` high updates the register at the next rising edge; with `wr_en` low, or a select of 18 to 31, nothing in the bank, flags or interrupt request changes.
- R3: TLB_IDX keeps bit 31 and loads bits 3:0 from the data, other bits zero; WIRED_LIM loads bits 3:0 only.
- R4: PTE_LO0 and PTE_LO1 store data AND 0x3FFFFFFF; PG_MASK stores data AND 0x01FFE000.
- R5: PT_CTX keeps bits 31:23, loads bits 22:4 from the data, and bits 3:0 become zero.
- R6: ASID_HI stores data AND 0xFFFFE0FF; when the written bits 7:0 differ from the stored bits 7:0, `tlb_flush` is high for exactly the one cycle after the write, and it stays low otherwise.
- R7: STATUS stores data AND 0xFA78FF01; a STATUS write sets `mode_user` to data bit 4, `mode_exl` to data bit 1 and `mode_erl` to data bit 2.
- R8: A STATUS write raises `irq_req` when data bit 0 is 1, stored STATUS bit 0 was 0, data bits 1 and 2 are 0, `mode_debug` is 0, and data[15:8] AND CAUSE[15:8] is nonzero.
- R9: A STATUS write with data bit 0 equal 0 while stored bit 0 was 1 clears `irq_req`; no other write or cycle changes it.
- R10: CAUSE keeps the bits of 0xB000F87C and loads the bits of 0x00C00300 (software interrupt bits 9:8 among them), other bits zero.
- R11: DBG_CTL keeps the bits of 0x8C03FC1F and loads the bits of 0x13300120; a DBG_CTL write sets `mode_debug` to data bit 30.
- R12: CONFIG0 keeps the bits of 0x8017FF80 and loads the bits of 0x7E000001, other bits zero.
- R13: WATCH_CTL stores data AND 0x40FF0FF8, CACHE_TAG stores data AND 0xFFFFFCF6; EXC_PC, DBG_PC, ERR_PC, WATCH_ADDR and DBG_SCRATCH store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | SEL_W (5) | Register select code |
| wr_data | input | DATA_W (32) | Write data |
| reg_bank | output | NREG*DATA_W (576) | All registers, register k at bits 32k+31:32k |
| mode_user | output | 1 | User-mode flag |
| mode_exl | output | 1 | Exception-level flag |
| mode_erl | output | 1 | Error-level flag |
| mode_debug | output | 1 | Debug-mode flag |
| irq_req | output | 1 | Registered hardware interrupt request |
| tlb_flush | output | 1 | One-cycle translation flush pulse |

## Verification
A wrong mask or a misdecoded select shows on `reg_bank` one cycle after the write, as a stray bit in a preserved, loaded or zeroed position or as a change in a register that was not addressed, so the bench compares the whole bank after every write of a sweep over all selects and a set of data patterns. A flag or interrupt request left in a wrong state is visible on its own port in the same cycle, but a stale interrupt-enable or cause value only surfaces at the next Status write, which is why the sweep interleaves Cause, debug and Status writes and the bench carries a running model. A flush fault appears as a missing pulse, a pulse on an unchanged ID, or a pulse lasting two cycles.

// File: rtl/cp0w_pkg.sv
package cp0w_pkg;

   localparam int NREG = 18;

   typedef enum logic [4:0] {
      SEL_STATUS      = 5'd0,
      SEL_CAUSE       = 5'd1,
      SEL_EXC_PC      = 5'd2,
      SEL_ASID_HI     = 5'd3,
      SEL_PTE_LO0     = 5'd4,
      SEL_PTE_LO1     = 5'd5,
      SEL_TLB_IDX     = 5'd6,
      SEL_PG_MASK     = 5'd7,
      SEL_WIRED_LIM   = 5'd8,
      SEL_PT_CTX      = 5'd9,
      SEL_CONFIG0     = 5'd10,
      SEL_DBG_CTL     = 5'd11,
      SEL_DBG_PC      = 5'd12,
      SEL_DBG_SCRATCH = 5'd13,
      SEL_ERR_PC      = 5'd14,
      SEL_CACHE_TAG   = 5'd15,
      SEL_WATCH_ADDR  = 5'd16,
      SEL_WATCH_CTL   = 5'd17
   } cp0_sel_e;

   // Bits that survive a write unchanged.
   function automatic logic [31:0] keep_mask(input int k);
      case (k)
         1:       return 32'hB000_F87C;
         6:       return 32'h8000_0000;
         9:       return 32'hFF80_0000;
         10:      return 32'h8017_FF80;
         11:      return 32'h8C03_FC1F;
         default: return 32'h0000_0000;
      endcase
   endfunction

   // Bits loaded from the write data.
   function automatic logic [31:0] take_mask(input int k);
      case (k)
         0:       return 32'hFA78_FF01;
         1:       return 32'h00C0_0300;
         3:       return 32'hFFFF_E0FF;
         4, 5:    return 32'h3FFF_FFFF;
         6, 8:    return 32'h0000_000F;
         7:       return 32'h01FF_E000;
         9:       return 32'h007F_FFF0;
         10:      return 32'h7E00_0001;
         11:      return 32'h1330_0120;
         15:      return 32'hFFFF_FCF6;
         17:      return 32'h40FF_0FF8;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [31:0] reset_val(input int k);
      case (k)
         0:       return 32'h0040_0000;
         1:       return 32'h3000_0000;
         6:       return 32'h8000_0000;
         9:       return 32'h1280_0000;
         10:      return 32'h8000_0082;
         11:      return 32'h0400_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

   // Bit positions that the mode logic decodes.
   localparam int ST_IE  = 0;
   localparam int ST_EXL = 1;
   localparam int ST_ERL = 2;
   localparam int ST_UM  = 4;
   localparam int DB_DM  = 30;

endpackage

// File: rtl/cp0w_mask_reg.sv
module cp0w_mask_reg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] KEEP = '0,
   parameter logic [W-1:0] TAKE = '0,
   parameter logic [W-1:0] RSTV = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] DEAD = ~(KEEP | TAKE);

   if ((KEEP & TAKE) != '0) begin : g_bad_masks
      $error("cp0w_mask_reg: preserve and load masks overlap");
   end

   always_ff @(posedge clk) begin
      if (rst)
         q <= RSTV;
      else if (we)
         q <= (q & KEEP) | (d & TAKE);
   end

   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q));

   a_r2_dead_bits_zero: assert property (@(posedge clk) disable iff (rst)
      we |=> ((q & DEAD) == '0));

   a_r2_keep_bits_stable: assert property (@(posedge clk) disable iff (rst)
      we |=> ((q & KEEP) == ($past(q) & KEEP)));

endmodule

// File: rtl/cp0w_mode_ctl.sv
module cp0w_mode_ctl #(
   parameter int IM_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stat_we,
   input  logic            dbg_we,
   input  logic            d_ie,
   input  logic            d_exl,
   input  logic            d_erl,
   input  logic            d_um,
   input  logic            d_dm,
   input  logic [IM_W-1:0] d_im,
   input  logic            old_ie,
   input  logic [IM_W-1:0] cause_ip,
   output logic            um_q,
   output logic            exl_q,
   output logic            erl_q,
   output logic            dm_q,
   output logic            irq_q
);

   logic ie_rise, ie_fall, pending;

   always_comb begin
      pending = |(d_im & cause_ip);
      ie_rise = d_ie && !old_ie;
      ie_fall = !d_ie && old_ie;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         um_q  <= 1'b0;
         exl_q <= 1'b0;
         erl_q <= 1'b1;
         dm_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (stat_we) begin
            um_q  <= d_um;
            exl_q <= d_exl;
            erl_q <= d_erl;
            if (ie_rise && !d_exl && !d_erl && !dm_q && pending)
               irq_q <= 1'b1;
            else if (ie_fall)
               irq_q <= 1'b0;
         end
         if (dbg_we)
            dm_q <= d_dm;
      end
   end

   a_r9_irq_only_on_status: assert property (@(posedge clk) disable iff (rst)
      !stat_we |=> $stable(irq_q));

   a_r8_irq_rise_needs_ie: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_q) |-> ($past(stat_we) && $past(d_ie) && !$past(old_ie)));

   a_r8_irq_rise_blocked: assert property (@(posedge clk) disable iff (rst)
      (stat_we && (d_exl || d_erl || dm_q) && !irq_q) |=> !irq_q);

   a_r9_irq_fall_on_clear: assert property (@(posedge clk) disable iff (rst)
      (stat_we && !d_ie && old_ie) |=> !irq_q);

   a_r7_flags_follow: assert property (@(posedge clk) disable iff (rst)
      stat_we |=> (exl_q == $past(d_exl) && erl_q == $past(d_erl) && um_q == $past(d_um)));

   a_r11_dm_follows: assert property (@(posedge clk) disable iff (rst)
      dbg_we |=> (dm_q == $past(d_dm)));

endmodule

// File: rtl/cp0w_asid_watch.sv
module cp0w_asid_watch #(
   parameter int ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ehi_we,
   input  logic [ASID_W-1:0] new_asid,
   input  logic [ASID_W-1:0] cur_asid,
   output logic              flush_q
);

   always_ff @(posedge clk) begin
      if (rst)
         flush_q <= 1'b0;
      else
         flush_q <= ehi_we && (new_asid != cur_asid);
   end

   a_r6_flush_after_write: assert property (@(posedge clk) disable iff (rst)
      flush_q |-> $past(ehi_we));

   a_r6_flush_one_cycle: assert property (@(posedge clk) disable iff (rst)
      (flush_q && !ehi_we) |=> !flush_q);

   a_r6_no_flush_same_id: assert property (@(posedge clk) disable iff (rst)
      (ehi_we && new_asid == cur_asid) |=> !flush_q);

endmodule

// File: rtl/cp0_write_unit.sv
module cp0_write_unit #(
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 5,
   parameter int ASID_W   = 8,
   parameter bit FLUSH_EN = 1'b1,
   localparam int NREG    = cp0w_pkg::NREG,
   localparam int BANK_W  = NREG * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [BANK_W-1:0] reg_bank,
   output logic              mode_user,
   output logic              mode_exl,
   output logic              mode_erl,
   output logic              mode_debug,
   output logic              irq_req,
   output logic              tlb_flush
);
   import cp0w_pkg::*;

   localparam int IM_LO = 8;
   localparam int IM_W  = 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("cp0_write_unit: register masks are defined for 32-bit data");
   end
   if ((1 << SEL_W) < NREG) begin : g_bad_sel
      $error("cp0_write_unit: select too narrow for the register count");
   end
   if (ASID_W < 1 || ASID_W > 8) begin : g_bad_asid
      $error("cp0_write_unit: address-space ID must fit in bits 7:0");
   end

   logic [DATA_W-1:0] q [NREG];
   logic [NREG-1:0]   we_vec;

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      assign we_vec[k] = wr_en && (wr_sel == SEL_W'(k));

      cp0w_mask_reg #(
         .W    (DATA_W),
         .KEEP (keep_mask(k)),
         .TAKE (take_mask(k)),
         .RSTV (reset_val(k))
      ) reg_i (
         .clk (clk),
         .rst (rst),
         .we  (we_vec[k]),
         .d   (wr_data),
         .q   (q[k])
      );

      assign reg_bank[k*DATA_W +: DATA_W] = q[k];
   end

   logic [DATA_W-1:0] status_q, cause_q, asid_hi_q;
   assign status_q  = q[SEL_STATUS];
   assign cause_q   = q[SEL_CAUSE];
   assign asid_hi_q = q[SEL_ASID_HI];

   cp0w_mode_ctl #(.IM_W(IM_W)) mode_i (
      .clk      (clk),
      .rst      (rst),
      .stat_we  (we_vec[SEL_STATUS]),
      .dbg_we   (we_vec[SEL_DBG_CTL]),
      .d_ie     (wr_data[ST_IE]),
      .d_exl    (wr_data[ST_EXL]),
      .d_erl    (wr_data[ST_ERL]),
      .d_um     (wr_data[ST_UM]),
      .d_dm     (wr_data[DB_DM]),
      .d_im     (wr_data[IM_LO +: IM_W]),
      .old_ie   (status_q[ST_IE]),
      .cause_ip (cause_q[IM_LO +: IM_W]),
      .um_q     (mode_user),
      .exl_q    (mode_exl),
      .erl_q    (mode_erl),
      .dm_q     (mode_debug),
      .irq_q    (irq_req)
   );

   if (FLUSH_EN) begin : g_flush
      cp0w_asid_watch #(.ASID_W(ASID_W)) asid_i (
         .clk      (clk),
         .rst      (rst),
         .ehi_we   (we_vec[SEL_ASID_HI]),
         .new_asid (wr_data[ASID_W-1:0]),
         .cur_asid (asid_hi_q[ASID_W-1:0]),
         .flush_q  (tlb_flush)
      );
   end else begin : g_no_flush
      assign tlb_flush = 1'b0;
   end

   a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
      $onehot0(we_vec));

   a_r2_unknown_sel_idle: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel >= SEL_W'(NREG)) |=> $stable(reg_bank));

endmodule

// File: tb/cp0_write_unit_tb_top.sv
`timescale 1ns/1ps
module cp0_write_unit_tb_top;

   localparam int NREG = 18;
   localparam real HALF = 4.0;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_en = 1'b0;
   logic [4:0]   wr_sel = '0;
   logic [31:0]  wr_data = '0;
   logic [NREG*32-1:0] reg_bank;
   logic mode_user, mode_exl, mode_erl, mode_debug, irq_req, tlb_flush;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] mdl [NREG];
   logic um_m, exl_m, erl_m, dm_m, irq_m, flush_m;

   always #(HALF) clk = ~clk;

   cp0_write_unit dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .reg_bank(reg_bank), .mode_user(mode_user), .mode_exl(mode_exl),
      .mode_erl(mode_erl), .mode_debug(mode_debug), .irq_req(irq_req),
      .tlb_flush(tlb_flush)
   );

   // Masks and reset values as the requirements state them.
   function automatic logic [31:0] keep_of(input int k);
      case (k)
         1: return 32'hB000F87C;   // R10
         6: return 32'h80000000;   // R3
         9: return 32'hFF800000;   // R5
         10: return 32'h8017FF80;  // R12
         11: return 32'h8C03FC1F;  // R11
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] take_of(input int k);
      case (k)
         0: return 32'hFA78FF01;   // R7
         1: return 32'h00C00300;   // R10
         3: return 32'hFFFFE0FF;   // R6
         4, 5: return 32'h3FFFFFFF; // R4
         6, 8: return 32'h0000000F; // R3
         7: return 32'h01FFE000;   // R4
         9: return 32'h007FFFF0;   // R5
         10: return 32'h7E000001;  // R12
         11: return 32'h13300120;  // R11
         15: return 32'hFFFFFCF6;  // R13
         17: return 32'h40FF0FF8;  // R13
         default: return 32'hFFFFFFFF;
      endcase
   endfunction

   function automatic logic [31:0] rst_of(input int k);
      case (k)
         0: return 32'h00400000;
         1: return 32'h30000000;
         6: return 32'h80000000;
         9: return 32'h12800000;
         10: return 32'h80000082;
         11: return 32'h04000000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input int k);
      case (k)
         0: return "R7";
         1: return "R10";
         3: return "R6";
         4, 5, 7: return "R4";
         6, 8: return "R3";
         9: return "R5";
         10: return "R12";
         11: return "R11";
         default: return "R13";
      endcase
   endfunction

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string ctx);
      for (int k = 0; k < NREG; k++)
         cmp({ctx, "/", tag_of(k)}, reg_bank[k*32 +: 32], mdl[k]);
      cmp({ctx, "/R7 flags"}, {29'd0, mode_user, mode_exl, mode_erl}, {29'd0, um_m, exl_m, erl_m});
      cmp({ctx, "/R11 debug flag"}, {31'd0, mode_debug}, {31'd0, dm_m});
      cmp({ctx, "/R8 R9 irq"}, {31'd0, irq_req}, {31'd0, irq_m});
      cmp({ctx, "/R6 flush"}, {31'd0, tlb_flush}, {31'd0, flush_m});
   endtask

   task automatic model_reset();
      for (int k = 0; k < NREG; k++) mdl[k] = rst_of(k);
      um_m = 0; exl_m = 0; erl_m = 1; dm_m = 0; irq_m = 0; flush_m = 0;
   endtask

   // One write: drive at a falling edge, the design captures at the next
   // rising edge, outputs are compared at the following falling edge.
   task automatic do_write(input logic en, input int sel, input logic [31:0] d, input string ctx);
      @(negedge clk);
      wr_en = en; wr_sel = sel[4:0]; wr_data = d;
      flush_m = en && sel == 3 && (d[7:0] != mdl[3][7:0]);
      if (en && sel == 0) begin
         if (d[0] && !mdl[0][0] && !d[1] && !d[2] && !dm_m && ((d[15:8] & mdl[1][15:8]) != 8'h0))
            irq_m = 1;
         else if (!d[0] && mdl[0][0])
            irq_m = 0;
         um_m = d[4]; exl_m = d[1]; erl_m = d[2];
      end
      if (en && sel == 11) dm_m = d[30];
      if (en && sel < NREG)
         mdl[sel] = (mdl[sel] & keep_of(sel)) | (d & take_of(sel));
      @(negedge clk);
      wr_en = 0;
      check_all(ctx);
   endtask

   task automatic idle_cycle(input string ctx);
      @(negedge clk);
      flush_m = 0;
      check_all(ctx);
   endtask

   initial begin : watchdog
      #(HALF * 2.0 * 150000.0);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] lfsr;
      logic [31:0] pats [4];
      pats[0] = 32'hFFFFFFFF; pats[1] = 32'h00000000;
      pats[2] = 32'hA5A5A5A5; pats[3] = 32'h5A5A5A5A;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 0;
      check_all("R1 reset");

      // R2: idle strobe and unknown selects leave everything alone.
      do_write(1'b0, 0, 32'hFFFFFFFF, "R2 wr_en low");
      do_write(1'b0, 3, 32'h000000AB, "R2 wr_en low asid");
      for (int s = NREG; s < 32; s++)
         do_write(1'b1, s, 32'hFFFFFFFF, "R2 unknown select");

      // R8/R9 directed interrupt sequence.
      do_write(1'b1, 1, 32'h00000100, "R10 soft int");
      do_write(1'b1, 0, 32'h00000101, "R8 raise");
      do_write(1'b1, 0, 32'h00000101, "R9 hold ie high");
      do_write(1'b1, 1, 32'h00000000, "R9 hold cause clear");
      do_write(1'b1, 0, 32'h00000100, "R9 clear");
      do_write(1'b1, 1, 32'h00000200, "R10 soft int 2");
      do_write(1'b1, 0, 32'h00000203, "R8 blocked by exl");
      do_write(1'b1, 0, 32'h00000200, "R9 ie low");
      do_write(1'b1, 0, 32'h00000205, "R8 blocked by erl");
      do_write(1'b1, 0, 32'h00000200, "R9 ie low 2");
      do_write(1'b1, 11, 32'h40000000, "R11 dm set");
      do_write(1'b1, 0, 32'h00000201, "R8 blocked by dm");
      do_write(1'b1, 0, 32'h00000200, "R9 ie low 3");
      do_write(1'b1, 11, 32'h00000000, "R11 dm clear");
      do_write(1'b1, 0, 32'h00000101, "R8 no pending match");
      do_write(1'b1, 0, 32'h00000000, "R9 ie low 4");
      do_write(1'b1, 0, 32'h00000211, "R8 raise user");
      do_write(1'b1, 1, 32'h00000000, "R9 cause clear");
      do_write(1'b1, 0, 32'h00000000, "R9 clear 2");

      // R6 flush pulse.
      do_write(1'b1, 3, 32'h12345677, "R6 id change");
      idle_cycle("R6 pulse ends");
      do_write(1'b1, 3, 32'hFFFFFF77, "R6 same id");
      do_write(1'b1, 3, 32'h00000078, "R6 id change 2");
      do_write(1'b1, 3, 32'h00000079, "R6 back to back");
      idle_cycle("R6 pulse ends 2");

      // Sweep every select over fixed and pseudo-random patterns.
      lfsr = 32'hC0DE1234;
      for (int rep = 0; rep < 12; rep++) begin
         for (int s = 0; s < NREG; s++) begin
            logic [31:0] d;
            if (rep < 4) d = pats[rep];
            else begin
               lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
               d = lfsr ^ (32'h9E3779B9 * s);
            end
            do_write(1'b1, s, d, "sweep");
         end
      end

      // Reset again mid-run.
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      model_reset();
      check_all("R1 second reset");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule